// File: doc/BRIEF.md
# Configurable Macrocell Register

This block is one storage cell of the kind found at the end of a programmable-logic product-term array. Static configuration inputs decide which clock it follows, which data it stores, whether a chip-wide clear reaches it, and whether its output shows the stored value or the combinational value that would feed it. The register can follow either of two global clock pins in true or inverted polarity. It can also follow that global clock with an active-high enable, or follow a clock built from logic, for example another cell's output or an I/O pin.

Preset and clear act asynchronously, without waiting for any clock edge. Product-term preset and clear are both active high, and clear has priority over preset. A dedicated active-low global clear can be routed into the clear term of each cell on its own. A power-on reset input drives the register low at start-up. A fast path lets the register load straight from a pin, skipping the combinational result.

The clock mode is a small enumerated selector (`CM_GLOBAL`, `CM_GATED`, `CM_ARRAY`, `CM_ARRAY_ALT`) decoded with a unique case. The cell holds no sequencing state beyond the stored bit. It has two transitions: a load on the active edge of the chosen clock, and an asynchronous forced value from the control logic.

Top module: `mc_macrocell_reg`

## Requirements
- R1: While `por_n` is low the register output `q_reg` is 0, and it is 0 from time zero when `por_n` starts low. `por_n` acts as an extra clear term.
- R2: `cfg_clk_mode` selects the clock source. 2'b00 and 2'b01 select the global clock. 2'b10 and 2'b11 select `pt_clk`, which loads on its rising edge. Edges on the clock source that is not selected do not change `q_reg`.
- R3: In the global modes, `cfg_gclk_pick` selects `gclk[cfg_gclk_pick]`. With `cfg_gclk_inv`=0 the register loads on the rising edge of that pin, and with `cfg_gclk_inv`=1 it loads on the falling edge. Edges on the other global pin have no effect.
- R4: In mode 2'b01 the register loads only while `pt_ena` is 1 and holds its value on an edge while `pt_ena` is 0. In every other mode `pt_ena` is ignored.
- R5: With `cfg_fast_in`=1 the register loads `pin_in`, and with `cfg_fast_in`=0 it loads `comb_in`. The input that is not selected is ignored.
- R6: `pt_pre`=1 forces `q_reg` to 1 and `pt_clr`=1 forces `q_reg` to 0. Both act at once, without a clock edge.
- R7: When clear and preset are asserted together, `q_reg` is 0.
- R8: With `cfg_gclr_en`=1, `gclr_n`=0 clears `q_reg` at once and blocks loads. With `cfg_gclr_en`=0, `gclr_n` has no effect.
- R9: `cell_out` equals `comb_in` when `cfg_out_bypass`=1 and equals `q_reg` when `cfg_out_bypass`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on reset, active low, clears the register |
| cfg_clk_mode | input | 2 | Clock mode: 00 global, 01 global with enable, 1x product-term clock |
| cfg_gclk_pick | input | PICK_W (1) | Index of the global clock pin used |
| cfg_gclk_inv | input | 1 | 1 selects the inverted global clock |
| cfg_fast_in | input | 1 | 1 loads from the direct pin path |
| cfg_gclr_en | input | 1 | 1 routes the global clear into this register |
| cfg_out_bypass | input | 1 | 1 drives the combinational value on cell_out |
| gclk | input | N_GCLK (2) | Global clock pins |
| pt_clk | input | 1 | Product-term clock |
| pt_ena | input | 1 | Product-term clock enable, active high |
| pt_pre | input | 1 | Product-term asynchronous preset, active high |
| pt_clr | input | 1 | Product-term asynchronous clear, active high |
| gclr_n | input | 1 | Global clear, active low |
| comb_in | input | WIDTH (1) | Combinational logic result |
| pin_in | input | WIDTH (1) | Direct pin input |
| q_reg | output | WIDTH (1) | Registered value |
| cell_out | output | WIDTH (1) | Selected cell output |

## Verification
The bench sweeps all four clock modes, both global pins, both polarities and both data sources. For every combination it pulses each clock line that is not selected before it pulses the selected one, and this shows whether the clock mux routes the right source. Sampling in the middle of the selected pulse separates a rising-edge load from a falling-edge load. Loading a value opposite to the input that is not selected shows which data source was taken. Enable-low pulses hold the value only in the gated mode. Overlapping preset, clear and global clear, applied while every clock is idle, show that these controls act at once, that clear has priority, and that the per-cell enable of the global clear is respected.

// File: rtl/mc_cell_pkg.sv
package mc_cell_pkg;

    typedef enum logic [1:0] {
        CM_GLOBAL    = 2'b00,
        CM_GATED     = 2'b01,
        CM_ARRAY     = 2'b10,
        CM_ARRAY_ALT = 2'b11
    } clk_mode_e;

endpackage

// File: rtl/mc_clock_select.sv
module mc_clock_select
    import mc_cell_pkg::*;
#(
    parameter int N_GCLK = 2,
    localparam int PICK_W = (N_GCLK > 1) ? $clog2(N_GCLK) : 1
) (
    input  clk_mode_e           mode,
    input  logic [N_GCLK-1:0]   gclk,
    input  logic [PICK_W-1:0]   pick,
    input  logic                inv,
    input  logic                pt_clk,
    output logic                clk_out,
    output logic                gated
);

    logic gsrc;

    // Chosen global pin, then the optional inversion
    assign gsrc = gclk[pick] ^ inv;

    always_comb begin
        clk_out = gsrc;
        gated   = 1'b0;
        unique case (mode)
            CM_GLOBAL: begin
                clk_out = gsrc;
                gated   = 1'b0;
            end
            CM_GATED: begin
                clk_out = gsrc;
                gated   = 1'b1;
            end
            CM_ARRAY, CM_ARRAY_ALT: begin
                clk_out = pt_clk;
                gated   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mc_data_select.sv
module mc_data_select #(
    parameter int WIDTH = 1
) (
    input  logic             fast_sel,
    input  logic [WIDTH-1:0] comb_in,
    input  logic [WIDTH-1:0] pin_in,
    input  logic             gated,
    input  logic             ena,
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] d_next,
    output logic             hold
);

    logic [WIDTH-1:0] d_src;

    assign d_src  = fast_sel ? pin_in : comb_in;
    // Enable is realised as a recirculating mux, the clock is never gated
    assign hold   = gated & ~ena;
    assign d_next = hold ? q : d_src;

endmodule

// File: rtl/mc_async_ctrl.sv
module mc_async_ctrl (
    input  logic por_n,
    input  logic gclr_en,
    input  logic gclr_n,
    input  logic pt_pre,
    input  logic pt_clr,
    output logic clr_any,
    output logic pre_any
);

    assign clr_any = ~por_n | pt_clr | (gclr_en & ~gclr_n);
    // Clear has priority over preset
    assign pre_any = pt_pre & ~clr_any;

endmodule

// File: rtl/mc_storage.sv
module mc_storage #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             pre,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk or posedge clr or posedge pre) begin
        if (clr) begin
            q <= '0;
        end else if (pre) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    // R6: an active clear leaves the stored value low at any clock edge
    assert_pt_clear_low_R6: assert property (@(posedge clk) clr |-> (q == '0));

    // R6: an active preset (without clear) leaves the stored value high
    assert_pt_preset_high_R6: assert property (@(posedge clk) (pre && !clr) |-> (q == '1));

endmodule

// File: rtl/mc_macrocell_reg.sv
module mc_macrocell_reg
    import mc_cell_pkg::*;
#(
    parameter int WIDTH  = 1,
    parameter int N_GCLK = 2,
    localparam int PICK_W = (N_GCLK > 1) ? $clog2(N_GCLK) : 1
) (
    input  logic              por_n,
    input  logic [1:0]        cfg_clk_mode,
    input  logic [PICK_W-1:0] cfg_gclk_pick,
    input  logic              cfg_gclk_inv,
    input  logic              cfg_fast_in,
    input  logic              cfg_gclr_en,
    input  logic              cfg_out_bypass,
    input  logic [N_GCLK-1:0] gclk,
    input  logic              pt_clk,
    input  logic              pt_ena,
    input  logic              pt_pre,
    input  logic              pt_clr,
    input  logic              gclr_n,
    input  logic [WIDTH-1:0]  comb_in,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  q_reg,
    output logic [WIDTH-1:0]  cell_out
);

    clk_mode_e        mode;
    logic             sel_clk;
    logic             gated;
    logic             hold;
    logic             clr_any;
    logic             pre_any;
    logic [WIDTH-1:0] d_next;
    logic [WIDTH-1:0] q;

    assign mode = clk_mode_e'(cfg_clk_mode);

    mc_clock_select #(.N_GCLK(N_GCLK)) u_clk_sel (
        .mode    (mode),
        .gclk    (gclk),
        .pick    (cfg_gclk_pick),
        .inv     (cfg_gclk_inv),
        .pt_clk  (pt_clk),
        .clk_out (sel_clk),
        .gated   (gated)
    );

    mc_data_select #(.WIDTH(WIDTH)) u_data_sel (
        .fast_sel (cfg_fast_in),
        .comb_in  (comb_in),
        .pin_in   (pin_in),
        .gated    (gated),
        .ena      (pt_ena),
        .q        (q),
        .d_next   (d_next),
        .hold     (hold)
    );

    mc_async_ctrl u_async (
        .por_n   (por_n),
        .gclr_en (cfg_gclr_en),
        .gclr_n  (gclr_n),
        .pt_pre  (pt_pre),
        .pt_clr  (pt_clr),
        .clr_any (clr_any),
        .pre_any (pre_any)
    );

    mc_storage #(.WIDTH(WIDTH)) u_store (
        .clk (sel_clk),
        .clr (clr_any),
        .pre (pre_any),
        .d   (d_next),
        .q   (q)
    );

    assign q_reg    = q;
    assign cell_out = cfg_out_bypass ? comb_in : q;

    // R4: an edge taken with the enable low keeps the stored value
    assert_hold_when_disabled_R4: assert property (@(posedge sel_clk) disable iff (!por_n)
        (hold && !clr_any && !pre_any) |=>
        (clr_any || pre_any || !$stable(cfg_clk_mode) || !$stable(cfg_gclk_pick) ||
         !$stable(cfg_gclk_inv) || (q == $past(q))));

    // R8: an enabled global clear keeps the register low at every edge
    assert_global_clear_low_R8: assert property (@(posedge sel_clk) disable iff (!por_n)
        (cfg_gclr_en && !gclr_n) |-> (q == '0));

endmodule

// File: tb/mc_macrocell_reg_tb.sv
module mc_macrocell_reg_tb_top;

    localparam int PERIOD = 10;
    localparam int HALF   = PERIOD / 2;

    logic       por_n;
    logic [1:0] cfg_clk_mode;
    logic [0:0] cfg_gclk_pick;
    logic       cfg_gclk_inv;
    logic       cfg_fast_in;
    logic       cfg_gclr_en;
    logic       cfg_out_bypass;
    logic [1:0] gclk;
    logic       pt_clk;
    logic       pt_ena;
    logic       pt_pre;
    logic       pt_clr;
    logic       gclr_n;
    logic [0:0] comb_in;
    logic [0:0] pin_in;
    logic [0:0] q_reg;
    logic [0:0] cell_out;

    int errs;
    int checks;

    mc_macrocell_reg dut_i (
        .por_n          (por_n),
        .cfg_clk_mode   (cfg_clk_mode),
        .cfg_gclk_pick  (cfg_gclk_pick),
        .cfg_gclk_inv   (cfg_gclk_inv),
        .cfg_fast_in    (cfg_fast_in),
        .cfg_gclr_en    (cfg_gclr_en),
        .cfg_out_bypass (cfg_out_bypass),
        .gclk           (gclk),
        .pt_clk         (pt_clk),
        .pt_ena         (pt_ena),
        .pt_pre         (pt_pre),
        .pt_clr         (pt_clr),
        .gclr_n         (gclr_n),
        .comb_in        (comb_in),
        .pin_in         (pin_in),
        .q_reg          (q_reg),
        .cell_out       (cell_out)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_line(input int s, input logic v);
        case (s)
            0:       gclk[0] = v;
            1:       gclk[1] = v;
            default: pt_clk  = v;
        endcase
    endtask

    // Drive the wanted value on the chosen data input and its complement on the other
    task automatic set_data(input logic f, input logic v);
        if (f) begin
            pin_in  = v;
            comb_in = ~v;
        end else begin
            comb_in = v;
            pin_in  = ~v;
        end
    endtask

    task automatic pulse(input int s);
        set_line(s, 1'b1);
        #HALF;
        set_line(s, 1'b0);
        #HALF;
    endtask

    initial begin
        #(PERIOD * 150000);
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs + 1, checks + 1);
        $finish;
    end

    initial begin
        errs = 0;
        checks = 0;
        por_n = 1'b0;
        cfg_clk_mode = 2'b00;
        cfg_gclk_pick = 1'b0;
        cfg_gclk_inv = 1'b0;
        cfg_fast_in = 1'b0;
        cfg_gclr_en = 1'b0;
        cfg_out_bypass = 1'b0;
        gclk = 2'b00;
        pt_clk = 1'b0;
        pt_ena = 1'b1;
        pt_pre = 1'b0;
        pt_clr = 1'b0;
        gclr_n = 1'b1;
        comb_in = 1'b1;
        pin_in = 1'b1;
        #1;
        chk("R1 power-up q_reg", q_reg[0], 1'b0);
        chk("R1 power-up cell_out", cell_out[0], 1'b0);
        pulse(0);
        chk("R1 edge ignored while por_n low", q_reg[0], 1'b0);
        por_n = 1'b1;
        #HALF;

        // Exhaustive sweep: mode x pin x polarity x data source
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int iv = 0; iv < 2; iv++) begin
                    for (int f = 0; f < 2; f++) begin
                        int  sel;
                        logic inv_eff;
                        cfg_clk_mode  = m[1:0];
                        cfg_gclk_pick = p[0:0];
                        cfg_gclk_inv  = iv[0];
                        cfg_fast_in   = f[0];
                        sel     = (m >= 2) ? 2 : p;
                        inv_eff = (m < 2) && (iv != 0);
                        #HALF;
                        pt_clr = 1'b1;
                        #1;
                        chk("R6 clear acts without clock", q_reg[0], 1'b0);
                        pt_clr = 1'b0;
                        #HALF;
                        set_data(f[0], 1'b1);
                        #1;
                        for (int s = 0; s < 3; s++) begin
                            if (s != sel) begin
                                pulse(s);
                                if (s < 2 && sel < 2)
                                    chk("R3 other global pin ignored", q_reg[0], 1'b0);
                                else
                                    chk("R2 unselected clock source ignored", q_reg[0], 1'b0);
                            end
                        end
                        set_line(sel, 1'b1);
                        #HALF;
                        chk("R3 load edge polarity", q_reg[0], inv_eff ? 1'b0 : 1'b1);
                        set_line(sel, 1'b0);
                        #HALF;
                        chk("R5 selected data source loaded", q_reg[0], 1'b1);
                        set_data(f[0], 1'b0);
                        pt_ena = 1'b0;
                        #1;
                        pulse(sel);
                        if (m == 1)
                            chk("R4 enable low holds", q_reg[0], 1'b1);
                        else
                            chk("R4 enable ignored outside gated mode", q_reg[0], 1'b0);
                        pt_ena = 1'b1;
                        #1;
                        pulse(sel);
                        chk("R4 enable high loads", q_reg[0], 1'b0);
                    end
                end
            end
        end

        // Asynchronous controls with every clock idle
        cfg_clk_mode  = 2'b00;
        cfg_gclk_pick = 1'b0;
        cfg_gclk_inv  = 1'b0;
        cfg_fast_in   = 1'b0;
        #HALF;
        pt_pre = 1'b1;
        #1;
        chk("R6 preset acts without clock", q_reg[0], 1'b1);
        pt_clr = 1'b1;
        #1;
        chk("R7 clear wins over preset", q_reg[0], 1'b0);
        pt_pre = 1'b0;
        #1;
        pt_clr = 1'b0;
        #1;
        chk("R7 low after release", q_reg[0], 1'b0);
        pt_pre = 1'b1;
        #1;
        pt_pre = 1'b0;
        #1;
        chk("R6 preset value retained", q_reg[0], 1'b1);

        cfg_gclr_en = 1'b0;
        gclr_n = 1'b0;
        #1;
        chk("R8 global clear disabled has no effect", q_reg[0], 1'b1);
        gclr_n = 1'b1;
        #1;
        cfg_gclr_en = 1'b1;
        gclr_n = 1'b0;
        #1;
        chk("R8 enabled global clear acts at once", q_reg[0], 1'b0);
        comb_in = 1'b1;
        #1;
        pulse(0);
        chk("R8 global clear blocks load", q_reg[0], 1'b0);
        gclr_n = 1'b1;
        #1;
        pulse(0);
        chk("R8 load after global clear released", q_reg[0], 1'b1);

        // Output selection
        comb_in = 1'b0;
        #1;
        chk("R9 cell_out follows register", cell_out[0], 1'b1);
        cfg_out_bypass = 1'b1;
        #1;
        chk("R9 bypass shows comb_in low", cell_out[0], 1'b0);
        comb_in = 1'b1;
        #1;
        chk("R9 bypass shows comb_in high", cell_out[0], 1'b1);
        comb_in = 1'b0;
        #1;
        chk("R9 register unaffected by bypass", q_reg[0], 1'b1);
        cfg_out_bypass = 1'b0;

        // Power-on reset in mid-run
        por_n = 1'b0;
        #1;
        chk("R1 por_n clears register", q_reg[0], 1'b0);
        por_n = 1'b1;
        #HALF;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule